// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a synchronous host and an asynchronous extended-data-out DRAM of 1M words by 4 bits. A host hands over one word per request through a request/ready handshake: a 20-bit word address, a write flag and 4 bits of write data. The sequencer turns each request into one random-access strobe sequence on the memory side. It drives the row half of the address and then the column half on one shared 10-pin bus, lowers the row and column strobes, steers the write-enable and output-enable strobes, and either drives the shared data pins or samples them.

Each analog timing limit is given in nanoseconds together with the clock period. The block rounds each limit up to whole cycles and combines them into a handful of fixed event times, which it counts from the falling edge of the row strobe. One counter therefore schedules the whole access: when the column address appears, when the column strobe falls, when read data is captured, when both strobes rise, and when the next request may be taken. After a read, the captured word is returned on a one-cycle valid pulse. Refresh and page bursts are the job of other logic.

Top module: `edo_seq`

## Requirements
- R1: In reset, and on the first cycle after it, the row, column, write and output strobes are all high, the data pins are released (high impedance), ready is high and the read-valid output is low.
- R2: The row is word address bits 19..10 and the column is bits 9..0. The row is on the memory address pins when the row strobe falls and stays there for at least the row hold time. The column is on the pins when the column strobe falls.
- R3: The column strobe falls only while the row strobe is low, and no earlier than the RAS-to-CAS delay (20 ns) after the row strobe fell.
- R4: The row strobe stays low for at least 60 ns. The column strobe stays low for at least 10 ns. The row strobe stays low for at least 15 ns after the column strobe falls. Both strobes rise on the same clock edge.
- R5: The row strobe stays high for at least 40 ns between accesses, and successive row-strobe falling edges are at least 104 ns apart.
- R6: In a read, write-enable stays high, output-enable is low whenever the column strobe is low, and the word read back equals the word last written to that address. Data is captured only after the row, column and address access times have all passed. Read-valid is high for exactly one cycle per read.
- R7: In a write, the write data is on the pins and write-enable is low when the column strobe falls, and output-enable stays high for the whole access. The data stays driven in the cycle after the column strobe rises and is released after that.
- R8: Ready falls on the cycle after a request is accepted and stays low through the whole access and precharge. A request raised and withdrawn while ready is low starts no access and changes no memory contents.
- R9: Read-valid never rises during a write access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, taken when ready is high |
| ready | output | 1 | Sequencer can take a request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Word address, row in bits 19..10 |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data |
| rvalid | output | 1 | One-cycle pulse, rdata valid |
| dram_a | output | 10 | Multiplexed memory address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq | inout | 4 | Memory data pins |

## Verification
The bench attaches a behavioural memory that returns the inverted word until the row access time has passed. A sequencer that captures too early therefore reads back wrong data, and one that reads the wrong cell does too. The stimulus is a mix of writes and reads. It uses all-ones and all-zero addresses, which catch row/column swaps and bit slips on the shared pins, and an overwrite of an earlier cell, which separates stored data from stale data. Every strobe edge is timed by a cycle-counting monitor against the nanosecond limits. Directed cases cover a request withdrawn while the sequencer is busy, and a reset taken in the middle of an access.

// File: rtl/edo_seq.sv
module edo_seq #(
  parameter int CLK_NS   = 10,
  parameter int AW       = 10,
  parameter int DW       = 4,
  parameter int T_RAH_NS = 10,
  parameter int T_RCD_NS = 20,
  parameter int T_RAC_NS = 60,
  parameter int T_CAC_NS = 15,
  parameter int T_AA_NS  = 30,
  parameter int T_RAS_NS = 60,
  parameter int T_CAS_NS = 10,
  parameter int T_RSH_NS = 15,
  parameter int T_CSH_NS = 60,
  parameter int T_RP_NS  = 40,
  parameter int T_RC_NS  = 104
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  output logic          ready,
  input  logic          we,
  input  logic [2*AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic [AW-1:0] dram_a,
  output logic          dram_ras_n,
  output logic          dram_cas_n,
  output logic          dram_we_n,
  output logic          dram_oe_n,
  inout  wire  [DW-1:0] dram_dq
);

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_RAH = cyc(T_RAH_NS);
  localparam int C_RCD = cyc(T_RCD_NS);
  localparam int C_RAC = cyc(T_RAC_NS);
  localparam int C_CAC = cyc(T_CAC_NS);
  localparam int C_AA  = cyc(T_AA_NS);
  localparam int C_RAS = cyc(T_RAS_NS);
  localparam int C_CAS = cyc(T_CAS_NS);
  localparam int C_RSH = cyc(T_RSH_NS);
  localparam int C_CSH = cyc(T_CSH_NS);
  localparam int C_RP  = cyc(T_RP_NS);
  localparam int C_RC  = cyc(T_RC_NS);

  localparam int T_COL  = mx(C_RAH, 1);
  localparam int T_CASF = mx(C_RCD, T_COL + 1);
  localparam int T_RD   = mx(mx(C_RAC, T_CASF + C_CAC), T_COL + C_AA) + 1;
  localparam int T_END  = mx(mx(mx(T_CASF + C_CAS, C_RAS), mx(T_CASF + C_RSH, C_CSH)), T_RD);
  localparam int T_PRE  = mx(mx(T_END + 1, T_END + C_RP - 2), C_RC - 2);
  localparam int TW     = $clog2(T_PRE + 2) + 1;

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_RCD, S_COL, S_ACCESS, S_PRE} state_t;

  state_t          state;
  logic [TW-1:0]   t;
  logic            wr_q;
  logic [AW-1:0]   col_q;
  logic [DW-1:0]   dq_q;
  logic            dq_oe_q;

  assign ready   = (state == S_IDLE);
  assign dram_dq = dq_oe_q ? dq_q : {DW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      t          <= '0;
      wr_q       <= 1'b0;
      col_q      <= '0;
      dq_q       <= '0;
      dq_oe_q    <= 1'b0;
      dram_a     <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_oe_n  <= 1'b1;
      rdata      <= '0;
      rvalid     <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      if (state != S_IDLE) t <= t + 1'b1;
      case (state)
        S_IDLE: if (req) begin
          dram_a <= addr[2*AW-1:AW];
          col_q  <= addr[AW-1:0];
          wr_q   <= we;
          dq_q   <= wdata;
          state  <= S_ROW;
        end
        S_ROW: begin
          dram_ras_n <= 1'b0;
          t          <= TW'(1);
          if (wr_q) begin
            dram_we_n <= 1'b0;
            dq_oe_q   <= 1'b1;
          end
          state <= S_RCD;
        end
        S_RCD: if (t >= TW'(T_COL)) begin
          dram_a <= col_q;
          state  <= S_COL;
        end
        S_COL: if (t >= TW'(T_CASF)) begin
          dram_cas_n <= 1'b0;
          dram_oe_n  <= wr_q;
          state      <= S_ACCESS;
        end
        S_ACCESS: begin
          if (!wr_q && t == TW'(T_RD)) begin
            rdata  <= dram_dq;
            rvalid <= 1'b1;
          end
          if (t >= TW'(T_END)) begin
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            dram_oe_n  <= 1'b1;
            state      <= S_PRE;
          end
        end
        S_PRE: begin
          dram_we_n <= 1'b1;
          dq_oe_q   <= 1'b0;
          if (t >= TW'(T_PRE)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/edo_seq_chk.sv
module edo_seq_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          rvalid,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [AW-1:0] a,
  input logic          dq_oe
);

  assert_cas_in_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  assert_cas_after_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> !$fell(ras_n));

  assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(a));

  assert_strobes_together_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $rose(cas_n));

  assert_we_oe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  assert_release_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $stable(dq_oe));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !ready);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  assert_no_valid_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> we_n);

endmodule

bind edo_seq edo_seq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rvalid(rvalid),
  .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
  .a(dram_a), .dq_oe(dq_oe_q)
);

// File: tb/edo_seq_tb_top.sv
module edo_seq_tb_top;

  localparam int LRAS = 3, LRP = 2, LRC = 6, LRCD = 1, LCAS = 1, LRSH = 1, LRAC = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, req, we, ready, rvalid;
  logic [19:0] addr;
  logic [3:0]  wdata, rdata;
  logic [9:0]  dram_a;
  logic        ras_n, cas_n, we_n, oe_n;
  wire  [3:0]  dq;
  logic        mdrv;
  logic [3:0]  mval;
  assign dq = mdrv ? mval : 4'bz;

  edo_seq #(.CLK_NS(20)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .dram_a(dram_a),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_dq(dq)
  );

  int checks = 0, bad = 0;
  int nacc = 0, nfall = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [3:0] mem [256];
  logic [9:0] exp_row, exp_col, cur_row, cur_col;
  logic [3:0] exp_wd;
  logic       exp_we;
  logic       pr = 1'b1, pc = 1'b1, prv = 1'b0, seen = 1'b0, cyc_wr = 1'b0;
  int rl = 0, rh = 100, rc = 100, cl = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      pr = 1'b1; pc = 1'b1; prv = 1'b0; seen = 1'b0; rh = 100; rl = 0; cl = 0;
      mdrv = 1'b0;
    end else begin
      if (pr && !ras_n) begin
        chk(rh >= LRP, "R5 ras high time", rh, LRP);
        if (seen) chk(rc >= LRC, "R5 ras fall spacing", rc, LRC);
        chk(dram_a == exp_row, "R2 row on pins at ras fall", dram_a, exp_row);
        cur_row = dram_a; cyc_wr = exp_we;
        rl = 1; rc = 0; seen = 1'b1; nfall++;
      end else if (!ras_n) rl++;
      if (!pr && ras_n) begin
        chk(rl >= LRAS, "R4 ras low time", rl, LRAS);
        chk(cas_n, "R4 strobes rise together", cas_n, 1);
        rh = 1;
      end else if (ras_n) rh++;
      rc++;
      if (!ras_n) chk(!ready, "R8 ready low while busy", ready, 0);

      if (pc && !cas_n) begin
        chk(!ras_n, "R3 cas inside ras", ras_n, 0);
        chk(rl - 1 >= LRCD, "R3 ras to cas delay", rl - 1, LRCD);
        chk(dram_a == exp_col, "R2 column on pins at cas fall", dram_a, exp_col);
        cur_col = dram_a;
        if (cyc_wr) begin
          chk(!we_n, "R7 we low at cas fall", we_n, 0);
          chk(dq === exp_wd, "R7 data driven at cas fall", dq, exp_wd);
          mem[{cur_row[3:0], cur_col[3:0]}] = dq;
        end else begin
          chk(we_n, "R6 we high in read", we_n, 1);
        end
        cl = 1;
      end else if (!cas_n) cl++;
      if (!pc && cas_n) begin
        chk(cl >= LCAS, "R4 cas low time", cl, LCAS);
        chk(cl >= LRSH, "R4 ras hold after cas", cl, LRSH);
        if (cyc_wr) chk(dq === exp_wd, "R7 data held after cas rise", dq, exp_wd);
      end
      if (!cas_n && cyc_wr) chk(oe_n, "R7 oe high in write", oe_n, 1);
      if (!cas_n && !cyc_wr) chk(!oe_n, "R6 oe low in read", oe_n, 0);

      if (rvalid) begin
        chk(!cyc_wr, "R9 no valid in write", cyc_wr, 0);
        chk(!prv, "R6 valid one cycle", prv, 0);
      end

      mdrv = !cas_n && !oe_n && we_n;
      mval = (rl >= LRAC) ? mem[{cur_row[3:0], cur_col[3:0]}]
                          : ~mem[{cur_row[3:0], cur_col[3:0]}];
      pr = ras_n; pc = cas_n; prv = rvalid;
    end
  end

  localparam logic [24:0] VEC [0:10] = '{
    {1'b1, 10'h2F3, 10'h155, 4'hA},
    {1'b1, 10'h0C1, 10'h2AA, 4'h5},
    {1'b0, 10'h2F3, 10'h155, 4'hA},
    {1'b0, 10'h0C1, 10'h2AA, 4'h5},
    {1'b1, 10'h3FF, 10'h3FF, 4'hF},
    {1'b1, 10'h000, 10'h000, 4'h0},
    {1'b0, 10'h3FF, 10'h3FF, 4'hF},
    {1'b0, 10'h000, 10'h000, 4'h0},
    {1'b1, 10'h2F3, 10'h155, 4'h3},
    {1'b0, 10'h2F3, 10'h155, 4'h3},
    {1'b0, 10'h0C1, 10'h2AA, 4'h5}
  };

  task automatic issue(input logic w, input logic [9:0] r, input logic [9:0] c,
                       input logic [3:0] d);
    while (!ready) @(negedge clk);
    req = 1'b1; we = w; addr = {r, c}; wdata = d;
    exp_row = r; exp_col = c; exp_wd = d; exp_we = w;
    @(negedge clk);
    chk(!ready, "R8 ready drops after accept", ready, 0);
    req = 1'b0;
    nacc++;
  endtask

  task automatic read_back(input logic [3:0] e);
    int n = 0;
    while (!rvalid && n < 60) begin @(negedge clk); n++; end
    chk(rvalid === 1'b1 && rdata === e, "R6 read data", rdata, e);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 4'h0;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    mdrv = 1'b0; mval = '0;
    exp_row = '0; exp_col = '0; exp_wd = '0; exp_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 strobes high after reset",
        {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(dq === 4'bz, "R1 data pins released", dq, 4'hF);
    chk(ready && !rvalid, "R1 ready high valid low", {ready, rvalid}, 2'b10);

    for (int i = 0; i < 11; i++) begin
      issue(VEC[i][24], VEC[i][23:14], VEC[i][13:4], VEC[i][3:0]);
      if (!VEC[i][24]) read_back(VEC[i][3:0]);
    end

    issue(1'b1, 10'h155, 10'h0AA, 4'h6);
    req = 1'b1; we = 1'b1; addr = {10'h011, 10'h022}; wdata = 4'h9;
    repeat (2) @(negedge clk);
    req = 1'b0;
    repeat (20) @(negedge clk);
    chk(nfall == nacc, "R8 withdrawn request starts no access", nfall, nacc);
    issue(1'b0, 10'h011, 10'h022, 4'h0);
    read_back(4'h0);
    issue(1'b0, 10'h155, 10'h0AA, 4'h6);
    read_back(4'h6);

    issue(1'b0, 10'h3FF, 10'h3FF, 4'hF);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF && ready && !rvalid,
        "R1 reset mid access", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && ras_n, "R1 ready after mid reset", ready, 1);
    issue(1'b0, 10'h0C1, 10'h2AA, 4'h5);
    read_back(4'h5);

    repeat (10) @(negedge clk);
    summary();
  end

endmodule